// File: doc/BRIEF.md
# Exception Entry Sequencer

This block sits beside a CPU pipeline and performs the architectural side of taking an exception. A general request carries the faulting PC, a cause code and, optionally, a faulting address. In one clock edge the block updates the status word, the saved-PC registers, the cause register and the fault-address register. It then picks the target vector (kernel, user or double) and produces a redirect PC. A separate debug-entry port enters the configured debug level. That entry saves the PC and the old status word in the slots for that level and raises the status word's interrupt level.

Register-window spill and fill exceptions arrive on the general port as plain vector indices: they redirect only and touch no special register. Every target can be relocated at run time. The configured vector address is offset by the difference between the live vector-base register and its reset value. A vector whose configured address is zero counts as absent, so the block raises an error pulse instead of a redirect. The pipeline can also write the status word and the vector base directly. Indexed read ports expose the saved-PC and saved-status register files.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the status word reads 0x10 (bits [3:0] interrupt level 0, bit 4 exception mode set, bit 5 user mode clear), the vector base equals its reset value, cause, debug cause, fault address and saved-PC registers read 0, taken_o and vec_err_o are low and both ready outputs are high.
- R2: A general request accepted with status bit 4 clear writes its PC to saved-PC slot 1 and its cause to the cause register, sets status bit 4, leaves bits [3:0] and 5 unchanged and targets the user vector when bit 5 is set, else the kernel vector.
- R3: A general request accepted with status bit 4 set is a double exception: its PC goes to the double-exception PC register (slot 1 unchanged), the cause register is written and the double vector is targeted.
- R4: An accepted general request with exc_addr_valid_i high writes exc_addr_i to the fault-address register; without it that register keeps its value.
- R5: An accepted debug request writes its cause to the debug-cause register, its PC to saved-PC slot DEBUG_LEVEL and the old status word to saved-status slot DEBUG_LEVEL. It sets the status word to {old bit 5, 1, DEBUG_LEVEL} and targets the debug vector.
- R6: A debug request is taken only when the effective level is below DEBUG_LEVEL. The effective level is bits [3:0], raised to EXCM_LEVEL while bit 4 is set. Otherwise it is consumed with no register change, no redirect and no error.
- R7: The redirect PC is the configured vector minus RESET_VECBASE plus the current vector-base register.
- R8: taken_o and redirect_pc_o appear in the cycle after acceptance, taken_o for exactly one cycle, and both ready outputs are low in that cycle so a waiting request is held off.
- R9: A target whose configured address is zero (window index 3 by default) gives a one-cycle vec_err_o in place of taken_o.
- R10: A general request with exc_win_i high redirects to window vector exc_win_idx_i and changes no special register.
- R11: When a debug entry is taken, exc_ready_o is low in the same cycle, so a simultaneous general request waits.
- R12: A status-word write in the same cycle as an accepted entry is discarded; the entry's status update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exc_valid_i | input | 1 | General exception request |
| exc_ready_o | output | 1 | General request accepted this cycle when valid |
| exc_win_i | input | 1 | Request is a window vector index |
| exc_win_idx_i | input | WIN_IDX_W | Window vector index |
| exc_pc_i | input | XLEN | Faulting PC |
| exc_cause_i | input | CAUSE_W | Exception cause code |
| exc_addr_valid_i | input | 1 | Request carries a fault address |
| exc_addr_i | input | XLEN | Fault address |
| dbg_valid_i | input | 1 | Debug entry request |
| dbg_ready_o | output | 1 | Debug request consumed this cycle when valid |
| dbg_pc_i | input | XLEN | PC saved on debug entry |
| dbg_cause_i | input | DCAUSE_W | Debug cause code |
| ps_we_i | input | 1 | Status word write enable |
| ps_wdata_i | input | 6 | Status word write data |
| vecbase_we_i | input | 1 | Vector-base write enable |
| vecbase_wdata_i | input | XLEN | Vector-base write data |
| taken_o | output | 1 | One-cycle entry strobe |
| redirect_pc_o | output | XLEN | Redirect target, valid with taken_o |
| vec_err_o | output | 1 | One-cycle absent-vector error |
| ps_o | output | 6 | Status word |
| vecbase_o | output | XLEN | Vector-base register |
| cause_o | output | CAUSE_W | Cause register |
| dbg_cause_o | output | DCAUSE_W | Debug cause register |
| vaddr_o | output | XLEN | Fault-address register |
| depc_o | output | XLEN | Double-exception PC register |
| epc_idx_i | input | IDX_W | Saved-PC read index (1..NLEVEL) |
| epc_o | output | XLEN | Saved-PC read data, 0 for other indices |
| eps_idx_i | input | IDX_W | Saved-status read index (2..NLEVEL) |
| eps_o | output | 6 | Saved-status read data, 0 for other indices |

## Verification
Every special-register update is due right after the clock edge that accepts a request. taken_o, redirect_pc_o and vec_err_o are due one cycle after acceptance and last one cycle. The ready outputs are combinational on current state and are checked before the edge that would accept. The bench drives inputs on the falling edge and checks the readies shortly after. It then lets exactly one rising edge pass and compares every output, plus two saved-register slots, against its behavioural model at the next falling edge. A stalled request is therefore seen as not accepted in the busy cycle and accepted one cycle later.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int PS_W      = 6;
  localparam int PS_LVL_W  = 4;
  localparam int PS_EXCM   = 4;
  localparam int PS_UM     = 5;

  typedef enum logic [2:0] {
    VSEL_KERNEL,
    VSEL_USER,
    VSEL_DOUBLE,
    VSEL_DEBUG,
    VSEL_WIN
  } vsel_e;

  // effective level: exception mode masks up to excm_lvl
  function automatic logic [PS_LVL_W-1:0] eff_level(logic [PS_W-1:0] ps,
                                                   logic [PS_LVL_W-1:0] excm_lvl);
    logic [PS_LVL_W-1:0] lvl;
    lvl = ps[PS_LVL_W-1:0];
    if (ps[PS_EXCM] && (lvl < excm_lvl)) lvl = excm_lvl;
    return lvl;
  endfunction
endpackage

// File: rtl/exc_vec_unit.sv
module exc_vec_unit
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NWIN = 4,
  parameter int WIN_IDX_W = 2,
  parameter bit RELOC_EN = 1'b1,
  parameter logic [XLEN-1:0] RESET_VECBASE = 32'h4000_0000,
  parameter logic [XLEN-1:0] KERNEL_VEC = 32'h4000_0300,
  parameter logic [XLEN-1:0] USER_VEC = 32'h4000_0340,
  parameter logic [XLEN-1:0] DOUBLE_VEC = 32'h4000_03C0,
  parameter logic [XLEN-1:0] DEBUG_VEC = 32'h4000_0280,
  parameter logic [NWIN-1:0][XLEN-1:0] WIN_VECS = '0
) (
  input  vsel_e               sel_i,
  input  logic [WIN_IDX_W-1:0] win_idx_i,
  input  logic [XLEN-1:0]     vecbase_i,
  output logic [XLEN-1:0]     target_o,
  output logic                invalid_o
);
  logic [XLEN-1:0] raw;

  always_comb begin
    raw = '0;
    unique case (sel_i)
      VSEL_KERNEL: raw = KERNEL_VEC;
      VSEL_USER:   raw = USER_VEC;
      VSEL_DOUBLE: raw = DOUBLE_VEC;
      VSEL_DEBUG:  raw = DEBUG_VEC;
      VSEL_WIN: begin
        for (int i = 0; i < NWIN; i++)
          if (win_idx_i == WIN_IDX_W'(i)) raw = WIN_VECS[i];
      end
      default:     raw = '0;
    endcase
  end

  assign invalid_o = (raw == '0);

  generate
    if (RELOC_EN) begin : g_reloc
      assign target_o = raw - RESET_VECBASE + vecbase_i;
    end else begin : g_fixed
      logic [XLEN-1:0] unused_vb;
      assign unused_vb = vecbase_i;
      assign target_o  = raw;
    end
  endgenerate
endmodule

// File: rtl/exc_sr_file.sv
module exc_sr_file #(
  parameter int XLEN   = 32,
  parameter int PS_W   = 6,
  parameter int NLEVEL = 6,
  parameter int IDX_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             epc_we_i,
  input  logic [IDX_W-1:0] epc_widx_i,
  input  logic [XLEN-1:0]  epc_wdata_i,
  input  logic             eps_we_i,
  input  logic [IDX_W-1:0] eps_widx_i,
  input  logic [PS_W-1:0]  eps_wdata_i,
  input  logic [IDX_W-1:0] epc_ridx_i,
  input  logic [IDX_W-1:0] eps_ridx_i,
  output logic [XLEN-1:0]  epc_o,
  output logic [PS_W-1:0]  eps_o
);
  logic [XLEN-1:0] epc_q [1:NLEVEL];
  logic [PS_W-1:0] eps_q [2:NLEVEL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 1; i <= NLEVEL; i++) epc_q[i] <= '0;
      for (int i = 2; i <= NLEVEL; i++) eps_q[i] <= '0;
    end else begin
      for (int i = 1; i <= NLEVEL; i++)
        if (epc_we_i && epc_widx_i == IDX_W'(i)) epc_q[i] <= epc_wdata_i;
      for (int i = 2; i <= NLEVEL; i++)
        if (eps_we_i && eps_widx_i == IDX_W'(i)) eps_q[i] <= eps_wdata_i;
    end
  end

  always_comb begin
    epc_o = '0;
    eps_o = '0;
    for (int i = 1; i <= NLEVEL; i++)
      if (epc_ridx_i == IDX_W'(i)) epc_o = epc_q[i];
    for (int i = 2; i <= NLEVEL; i++)
      if (eps_ridx_i == IDX_W'(i)) eps_o = eps_q[i];
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CAUSE_W = 6,
  parameter int DCAUSE_W = 6,
  parameter int NLEVEL = 6,
  parameter int DEBUG_LEVEL = 6,
  parameter int EXCM_LEVEL = 1,
  parameter bit HAS_DEPC = 1'b1,
  parameter bit RELOC_EN = 1'b1,
  parameter int NWIN = 4,
  parameter int WIN_IDX_W = 2,
  parameter int IDX_W = 3,
  parameter logic [XLEN-1:0] RESET_VECBASE = 32'h4000_0000,
  parameter logic [XLEN-1:0] KERNEL_VEC = 32'h4000_0300,
  parameter logic [XLEN-1:0] USER_VEC = 32'h4000_0340,
  parameter logic [XLEN-1:0] DOUBLE_VEC = 32'h4000_03C0,
  parameter logic [XLEN-1:0] DEBUG_VEC = 32'h4000_0280,
  parameter logic [NWIN-1:0][XLEN-1:0] WIN_VECS =
    {32'h0000_0000, 32'h4000_00C0, 32'h4000_0080, 32'h4000_0040}
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 exc_valid_i,
  output logic                 exc_ready_o,
  input  logic                 exc_win_i,
  input  logic [WIN_IDX_W-1:0] exc_win_idx_i,
  input  logic [XLEN-1:0]      exc_pc_i,
  input  logic [CAUSE_W-1:0]   exc_cause_i,
  input  logic                 exc_addr_valid_i,
  input  logic [XLEN-1:0]      exc_addr_i,
  input  logic                 dbg_valid_i,
  output logic                 dbg_ready_o,
  input  logic [XLEN-1:0]      dbg_pc_i,
  input  logic [DCAUSE_W-1:0]  dbg_cause_i,
  input  logic                 ps_we_i,
  input  logic [5:0]           ps_wdata_i,
  input  logic                 vecbase_we_i,
  input  logic [XLEN-1:0]      vecbase_wdata_i,
  output logic                 taken_o,
  output logic [XLEN-1:0]      redirect_pc_o,
  output logic                 vec_err_o,
  output logic [5:0]           ps_o,
  output logic [XLEN-1:0]      vecbase_o,
  output logic [CAUSE_W-1:0]   cause_o,
  output logic [DCAUSE_W-1:0]  dbg_cause_o,
  output logic [XLEN-1:0]      vaddr_o,
  output logic [XLEN-1:0]      depc_o,
  input  logic [IDX_W-1:0]     epc_idx_i,
  output logic [XLEN-1:0]      epc_o,
  input  logic [IDX_W-1:0]     eps_idx_i,
  output logic [5:0]           eps_o
);
  localparam logic [PS_LVL_W-1:0] DBG_LVL  = PS_LVL_W'(DEBUG_LEVEL);
  localparam logic [PS_LVL_W-1:0] EXCM_LVL = PS_LVL_W'(EXCM_LEVEL);
  localparam logic [IDX_W-1:0]    DBG_IDX  = IDX_W'(DEBUG_LEVEL);

  logic [PS_W-1:0]     ps_q, ps_d;
  logic [XLEN-1:0]     vecbase_q, vaddr_q;
  logic [CAUSE_W-1:0]  cause_q;
  logic [DCAUSE_W-1:0] dcause_q;
  logic                taken_q, err_q;
  logic [XLEN-1:0]     redir_q;

  logic busy, dbg_go, exc_go, gen_go, is_double;
  logic [XLEN-1:0] target;
  logic            target_bad;
  vsel_e           vsel;

  assign busy      = taken_q | err_q;
  assign dbg_go    = dbg_valid_i && !busy && (eff_level(ps_q, EXCM_LVL) < DBG_LVL);
  assign exc_ready_o = !busy && !dbg_go;
  assign dbg_ready_o = !busy;
  assign exc_go    = exc_valid_i && exc_ready_o;
  assign gen_go    = exc_go && !exc_win_i;
  assign is_double = ps_q[PS_EXCM];

  always_comb begin
    if (dbg_go)              vsel = VSEL_DEBUG;
    else if (exc_win_i)      vsel = VSEL_WIN;
    else if (is_double)      vsel = VSEL_DOUBLE;
    else if (ps_q[PS_UM])    vsel = VSEL_USER;
    else                     vsel = VSEL_KERNEL;
  end

  exc_vec_unit #(
    .XLEN(XLEN), .NWIN(NWIN), .WIN_IDX_W(WIN_IDX_W), .RELOC_EN(RELOC_EN),
    .RESET_VECBASE(RESET_VECBASE), .KERNEL_VEC(KERNEL_VEC), .USER_VEC(USER_VEC),
    .DOUBLE_VEC(DOUBLE_VEC), .DEBUG_VEC(DEBUG_VEC), .WIN_VECS(WIN_VECS)
  ) u_vec (
    .sel_i(vsel), .win_idx_i(exc_win_idx_i), .vecbase_i(vecbase_q),
    .target_o(target), .invalid_o(target_bad)
  );

  // status word next value: entry beats a software write
  always_comb begin
    ps_d = ps_q;
    if (dbg_go) begin
      ps_d[PS_LVL_W-1:0] = DBG_LVL;
      ps_d[PS_EXCM]      = 1'b1;
    end else if (gen_go) begin
      ps_d[PS_EXCM]      = 1'b1;
    end else if (ps_we_i) begin
      ps_d = ps_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q      <= PS_W'(1) << PS_EXCM;
      vecbase_q <= RESET_VECBASE;
      vaddr_q   <= '0;
      cause_q   <= '0;
      dcause_q  <= '0;
      taken_q   <= 1'b0;
      err_q     <= 1'b0;
      redir_q   <= '0;
    end else begin
      ps_q <= ps_d;
      if (vecbase_we_i)                vecbase_q <= vecbase_wdata_i;
      if (gen_go && exc_addr_valid_i)  vaddr_q   <= exc_addr_i;
      if (gen_go)                      cause_q   <= exc_cause_i;
      if (dbg_go)                      dcause_q  <= dbg_cause_i;
      taken_q <= (dbg_go || exc_go) && !target_bad;
      err_q   <= (dbg_go || exc_go) &&  target_bad;
      if ((dbg_go || exc_go) && !target_bad) redir_q <= target;
    end
  end

  generate
    if (HAS_DEPC) begin : g_depc
      logic [XLEN-1:0] depc_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  depc_q <= '0;
        else if (gen_go && is_double) depc_q <= exc_pc_i;
      end
      assign depc_o = depc_q;
    end else begin : g_no_depc
      assign depc_o = '0;
    end
  endgenerate

  logic             epc_we;
  logic [IDX_W-1:0] epc_widx;
  logic [XLEN-1:0]  epc_wdata;

  assign epc_we    = dbg_go || (gen_go && !(is_double && HAS_DEPC));
  assign epc_widx  = dbg_go ? DBG_IDX : IDX_W'(1);
  assign epc_wdata = dbg_go ? dbg_pc_i : exc_pc_i;

  exc_sr_file #(.XLEN(XLEN), .PS_W(PS_W), .NLEVEL(NLEVEL), .IDX_W(IDX_W)) u_sr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .epc_we_i(epc_we), .epc_widx_i(epc_widx), .epc_wdata_i(epc_wdata),
    .eps_we_i(dbg_go), .eps_widx_i(DBG_IDX), .eps_wdata_i(ps_q),
    .epc_ridx_i(epc_idx_i), .eps_ridx_i(eps_idx_i),
    .epc_o(epc_o), .eps_o(eps_o)
  );

  assign taken_o       = taken_q;
  assign vec_err_o     = err_q;
  assign redirect_pc_o = redir_q;
  assign ps_o          = ps_q;
  assign vecbase_o     = vecbase_q;
  assign cause_o       = cause_q;
  assign dbg_cause_o   = dcause_q;
  assign vaddr_o       = vaddr_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN = 32,
  parameter int DEBUG_LEVEL = 6,
  parameter int EXCM_LEVEL = 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            exc_valid_i,
  input logic            exc_ready_o,
  input logic            exc_win_i,
  input logic            exc_addr_valid_i,
  input logic [XLEN-1:0] exc_addr_i,
  input logic            dbg_valid_i,
  input logic            dbg_ready_o,
  input logic            ps_we_i,
  input logic            taken_o,
  input logic            vec_err_o,
  input logic [5:0]      ps_o,
  input logic [XLEN-1:0] vaddr_o
);
  logic [3:0] lvl;
  logic       dbg_ok;
  always_comb begin
    lvl = ps_o[3:0];
    if (ps_o[4] && int'(lvl) < EXCM_LEVEL) lvl = 4'(EXCM_LEVEL);
  end
  assign dbg_ok = int'(lvl) < DEBUG_LEVEL;

  // R8
  taken_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |=> !taken_o);
  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o || vec_err_o) |-> (!exc_ready_o && !dbg_ready_o));
  // R9
  err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(taken_o && vec_err_o));
  // R2
  excm_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i && exc_ready_o && !exc_win_i) |=> ps_o[4]);
  // R5
  dbg_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_valid_i && dbg_ready_o && dbg_ok) |=> (ps_o[3:0] == 4'(DEBUG_LEVEL) && ps_o[4]));
  // R6
  dbg_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_valid_i && dbg_ready_o && !dbg_ok && !exc_valid_i && !ps_we_i)
      |=> ($stable(ps_o) && !taken_o && !vec_err_o));
  // R4
  vaddr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i && exc_ready_o && !exc_win_i && exc_addr_valid_i)
      |=> (vaddr_o == $past(exc_addr_i)));
  // R11
  prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_valid_i && dbg_ready_o && dbg_ok) |-> !exc_ready_o);
endmodule

bind exc_entry_seq exc_entry_chk #(
  .XLEN(XLEN), .DEBUG_LEVEL(DEBUG_LEVEL), .EXCM_LEVEL(EXCM_LEVEL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .exc_valid_i(exc_valid_i), .exc_ready_o(exc_ready_o), .exc_win_i(exc_win_i),
  .exc_addr_valid_i(exc_addr_valid_i), .exc_addr_i(exc_addr_i),
  .dbg_valid_i(dbg_valid_i), .dbg_ready_o(dbg_ready_o), .ps_we_i(ps_we_i),
  .taken_o(taken_o), .vec_err_o(vec_err_o), .ps_o(ps_o), .vaddr_o(vaddr_o)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  localparam int          DL   = 6;
  localparam int          NL   = 6;
  localparam logic [31:0] RVB  = 32'h4000_0000;
  localparam logic [31:0] KV   = 32'h4000_0300;
  localparam logic [31:0] UV   = 32'h4000_0340;
  localparam logic [31:0] DV   = 32'h4000_03C0;
  localparam logic [31:0] BV   = 32'h4000_0280;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic        exc_valid = 0, exc_win = 0, exc_addr_valid = 0;
  logic [1:0]  exc_win_idx = 0;
  logic [31:0] exc_pc = 0, exc_addr = 0;
  logic [5:0]  exc_cause = 0;
  logic        dbg_valid = 0;
  logic [31:0] dbg_pc = 0;
  logic [5:0]  dbg_cause = 0;
  logic        ps_we = 0, vb_we = 0;
  logic [5:0]  ps_wdata = 0;
  logic [31:0] vb_wdata = 0;
  logic [2:0]  epc_idx = 0, eps_idx = 0;

  logic        exc_ready, dbg_ready, taken, vec_err;
  logic [31:0] redirect_pc, vecbase, vaddr, depc, epc;
  logic [5:0]  ps, cause, dcause, eps;

  exc_entry_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .exc_valid_i(exc_valid), .exc_ready_o(exc_ready), .exc_win_i(exc_win),
    .exc_win_idx_i(exc_win_idx), .exc_pc_i(exc_pc), .exc_cause_i(exc_cause),
    .exc_addr_valid_i(exc_addr_valid), .exc_addr_i(exc_addr),
    .dbg_valid_i(dbg_valid), .dbg_ready_o(dbg_ready), .dbg_pc_i(dbg_pc),
    .dbg_cause_i(dbg_cause), .ps_we_i(ps_we), .ps_wdata_i(ps_wdata),
    .vecbase_we_i(vb_we), .vecbase_wdata_i(vb_wdata),
    .taken_o(taken), .redirect_pc_o(redirect_pc), .vec_err_o(vec_err),
    .ps_o(ps), .vecbase_o(vecbase), .cause_o(cause), .dbg_cause_o(dcause),
    .vaddr_o(vaddr), .depc_o(depc), .epc_idx_i(epc_idx), .epc_o(epc),
    .eps_idx_i(eps_idx), .eps_o(eps)
  );

  int n_chk = 0, n_bad = 0, n_cyc = 0;
  string tag = "R1";

  // reference model state
  logic [5:0]  m_ps = 6'h10, m_cause = 0, m_dcause = 0;
  logic [31:0] m_vb = RVB, m_vaddr = 0, m_depc = 0, m_red = 0;
  logic        m_taken = 0, m_err = 0;
  logic [31:0] m_epc [8];
  logic [5:0]  m_eps [8];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] win_vec(int i);
    case (i)
      0: return 32'h4000_0040;
      1: return 32'h4000_0080;
      2: return 32'h4000_00C0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic compare_state();
    chk(tag, "taken", {31'b0, taken}, {31'b0, m_taken});
    chk(tag, "vec_err", {31'b0, vec_err}, {31'b0, m_err});
    if (m_taken) chk(tag, "redirect", redirect_pc, m_red);
    chk(tag, "ps", {26'b0, ps}, {26'b0, m_ps});
    chk(tag, "vecbase", vecbase, m_vb);
    chk(tag, "cause", {26'b0, cause}, {26'b0, m_cause});
    chk(tag, "dcause", {26'b0, dcause}, {26'b0, m_dcause});
    chk(tag, "vaddr", vaddr, m_vaddr);
    chk(tag, "depc", depc, m_depc);
    for (int k = 0; k < 2; k++) begin
      int idx;
      idx = ((n_cyc % 4) * 2) + k;
      epc_idx = 3'(idx);
      eps_idx = 3'(idx);
      #1;
      chk(tag, "epc", epc, (idx >= 1 && idx <= NL) ? m_epc[idx] : 32'h0);
      chk(tag, "eps", {26'b0, eps}, (idx >= 2 && idx <= NL) ? {26'b0, m_eps[idx]} : 32'h0);
    end
  endtask

  // one cycle: inputs already driven at a falling edge
  task automatic tick();
    logic busy, d_go, e_go, g_go, bad;
    logic [5:0]  n_ps;
    logic [31:0] vec;
    int lvl;
    #1;
    busy = m_taken | m_err;
    lvl = int'(m_ps[3:0]);
    if (m_ps[4] && lvl < 1) lvl = 1;
    d_go = dbg_valid && !busy && (lvl < DL);
    e_go = exc_valid && !busy && !d_go;
    g_go = e_go && !exc_win;
    chk(tag, "dbg_ready", {31'b0, dbg_ready}, {31'b0, !busy});
    chk(tag, "exc_ready", {31'b0, exc_ready}, {31'b0, !busy && !d_go});
    vec = 0;
    n_ps = m_ps;
    if (d_go) begin
      vec = BV;
      m_dcause = dbg_cause;
      m_epc[DL] = dbg_pc;
      m_eps[DL] = m_ps;
      n_ps = {m_ps[5], 1'b1, 4'(DL)};
    end else if (e_go && exc_win) begin
      vec = win_vec(int'(exc_win_idx));
      if (ps_we) n_ps = ps_wdata;
    end else if (g_go) begin
      if (m_ps[4]) begin
        vec = DV;
        m_depc = exc_pc;
      end else begin
        vec = m_ps[5] ? UV : KV;
        m_epc[1] = exc_pc;
      end
      m_cause = exc_cause;
      if (exc_addr_valid) m_vaddr = exc_addr;
      n_ps = m_ps | 6'h10;
    end else if (ps_we) n_ps = ps_wdata;
    bad = (vec == 0);
    m_taken = (d_go || e_go) && !bad;
    m_err   = (d_go || e_go) && bad;
    if (m_taken) m_red = vec - RVB + m_vb;
    m_ps = n_ps;
    if (vb_we) m_vb = vb_wdata;
    @(posedge clk);
    @(negedge clk);
    n_cyc++;
    exc_valid = 0; exc_win = 0; exc_addr_valid = 0; dbg_valid = 0;
    ps_we = 0; vb_we = 0;
    compare_state();
  endtask

  task automatic gen_req(logic [31:0] pc, logic [5:0] c, logic av, logic [31:0] a);
    exc_valid = 1; exc_pc = pc; exc_cause = c; exc_addr_valid = av; exc_addr = a;
  endtask

  task automatic set_ps(logic [5:0] v);
    ps_we = 1; ps_wdata = v; tick();
  endtask

  initial begin
    int limit = 20000;
    repeat (limit) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_epc[i] = 0; m_eps[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    tag = "R1";
    chk("R1", "dbg_ready", {31'b0, dbg_ready}, 32'h1);
    chk("R1", "exc_ready", {31'b0, exc_ready}, 32'h1);
    compare_state();
    tick();

    // R2 kernel entry
    set_ps(6'h00);
    tag = "R2";
    gen_req(32'h0000_1000, 6'd3, 0, 32'h0);
    tick();
    // R8 request held during busy cycle, then R3 double
    tag = "R8";
    gen_req(32'h0000_2000, 6'd7, 0, 32'h0);
    tick();
    tag = "R3";
    gen_req(32'h0000_2000, 6'd7, 0, 32'h0);
    tick();
    tick();

    // R12 status write colliding with an entry
    tag = "R12";
    ps_we = 1; ps_wdata = 6'h20;
    gen_req(32'h0000_2400, 6'd8, 0, 32'h0);
    tick();
    tick();

    // R2 user vector with R4 address
    set_ps(6'h20);
    tag = "R4";
    gen_req(32'h0000_3000, 6'd9, 1, 32'hDEAD_BEEF);
    tick();
    tick();
    set_ps(6'h20);
    tag = "R4";
    gen_req(32'h0000_3100, 6'd10, 0, 32'h1111_1111);
    tick();
    tick();

    // R7 relocation
    tag = "R7";
    vb_we = 1; vb_wdata = 32'h8000_0000;
    tick();
    set_ps(6'h00);
    tag = "R7";
    gen_req(32'h0000_4000, 6'd4, 0, 32'h0);
    tick();
    tick();

    // R5 debug entry
    set_ps(6'h23);
    tag = "R5";
    dbg_valid = 1; dbg_pc = 32'h0000_5000; dbg_cause = 6'h2A;
    tick();
    tick();
    // R6 suppressed at debug level and above
    tag = "R6";
    dbg_valid = 1; dbg_pc = 32'h0000_5100; dbg_cause = 6'h15;
    tick();
    set_ps(6'h07);
    tag = "R6";
    dbg_valid = 1; dbg_pc = 32'h0000_5200; dbg_cause = 6'h16;
    tick();
    // R6 exception mode raises level to 1, still below debug level
    set_ps(6'h10);
    tag = "R6";
    dbg_valid = 1; dbg_pc = 32'h0000_5300; dbg_cause = 6'h17;
    tick();
    tick();

    // R11 debug beats a simultaneous general request
    set_ps(6'h00);
    tag = "R11";
    dbg_valid = 1; dbg_pc = 32'h0000_6000; dbg_cause = 6'h01;
    gen_req(32'h0000_6100, 6'd2, 0, 32'h0);
    tick();
    gen_req(32'h0000_6100, 6'd2, 0, 32'h0);
    tick();
    gen_req(32'h0000_6100, 6'd2, 0, 32'h0);
    tick();
    tick();

    // R10 window vectors, R9 absent vector
    set_ps(6'h00);
    for (int w = 0; w < 4; w++) begin
      tag = (w == 3) ? "R9" : "R10";
      exc_valid = 1; exc_win = 1; exc_win_idx = 2'(w);
      exc_pc = 32'h0000_7000 + 32'(w); exc_cause = 6'd33;
      exc_addr_valid = 1; exc_addr = 32'hAAAA_0000 + 32'(w);
      tick();
      tick();
    end

    // R9 error blocks one cycle; R7 back to reset base
    tag = "R7";
    vb_we = 1; vb_wdata = RVB;
    tick();

    // R2 R3 R4 mixed patterns
    for (int i = 0; i < 8; i++) begin
      set_ps((i % 2) ? 6'h20 : 6'h00);
      tag = "R2";
      gen_req(32'h0001_0000 + 32'(i * 16), 6'(i + 1), (i % 3) == 0, 32'hC000_0000 + 32'(i));
      tick();
      tag = "R3";
      gen_req(32'h0002_0000 + 32'(i * 16), 6'(i + 20), (i % 3) == 1, 32'hC100_0000 + 32'(i));
      tick();
      gen_req(32'h0002_0000 + 32'(i * 16), 6'(i + 20), (i % 3) == 1, 32'hC100_0000 + 32'(i));
      tick();
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule